// File: doc/BRIEF.md
# USB Resume Signaling Controller

This block sequences resume signaling for a USB port that can work as a host or as a device. On a resume request it drives the K state onto the bus for a duration that depends on the role latched when driving starts. It then releases the bus. In host role it then holds off downstream traffic for a blackout window and enables start-of-frame generation so that the link does not drop back into suspend.

The block also watches the sampled line. A K state that holds for a set number of consecutive clock cycles produces a single-cycle resume-detected interrupt. In host role, that detection starts the block's own resume drive at once. Any bus activity while the port is suspended, and any start of a resume drive, raise a suspend-exit indication.

All durations are parameters. Drive and blackout lengths are counted in microsecond ticks, and the detection threshold is counted in clock cycles.

Top module: `usb_resume_ctrl`

## Requirements
- R1: After reset, `drive_en` is 0, `traffic_ok` is 1, `resume_irq` is 0, `sof_en` is 0 and `susp_exit` is 0.
- R2: A resume request in device role (`host_mode`=0) drives the bus for exactly `DEV_US` microsecond ticks. While `drive_en` is 1, `drive_line` is K (2'b10); otherwise it is J (2'b01).
- R3: A resume request in host role drives the bus for exactly `HOST_US` ticks.
- R4: After a host-role drive ends, `traffic_ok` stays 0 for exactly `QUIET_US` further ticks. After a device-role drive ends, `traffic_ok` is 1 in the same cycle that `drive_en` falls. `traffic_ok` is 0 throughout any drive.
- R5: `resume_irq` pulses for one cycle once `line_state` has been K (2'b10) for `DET_CYC` consecutive clock cycles. A K run that is shorter than this gives no pulse, and a new run starts counting from zero.
- R6: While the block is driving, the line is not examined and `resume_irq` stays 0.
- R7: In host role, a resume detection while the block is idle starts a drive of `HOST_US` ticks without any request.
- R8: A resume request that arrives during a drive or during the blackout window is ignored. It neither lengthens the drive nor starts a new one.
- R9: `sof_en` becomes 1 when a host-role drive ends. It returns to 0 when `host_mode` is 0.
- R10: While `bus_suspended` is 1, `susp_exit` becomes 1 one cycle after a line state other than J (with the block not driving), or after the start of a drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| resume_req | input | 1 | Request to drive resume |
| bus_suspended | input | 1 | Link is in the low-power suspend state |
| line_state | input | 2 | Sampled line: 00 SE0, 01 J, 10 K, 11 SE1 |
| drive_en | output | 1 | Block drives the bus |
| drive_line | output | 2 | Line state being driven |
| resume_irq | output | 1 | Resume-detected pulse |
| susp_exit | output | 1 | Suspend-exit indication |
| sof_en | output | 1 | Start-of-frame generation enable |
| traffic_ok | output | 1 | Downstream traffic permitted |

## Verification
On every cycle, the assertions check the following:
- a detection pulse lasts one cycle and always follows a K sample;
- the blackout state never leads straight back into driving;
- traffic is never permitted while the bus is driven;
- the interval counter stays within its loaded range.

The exact drive and blackout lengths counted in ticks, the suppression of requests in mid-sequence, the host's automatic answer to incoming resume, and the start-of-frame enable can only be shown by the bench's timed scenarios. Those scenarios include random K bursts around the detection threshold.

// File: rtl/usres_pkg.sv
package usres_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DRIVE, ST_QUIET} usres_st_t;
  localparam logic [1:0] LN_SE0 = 2'b00;
  localparam logic [1:0] LN_J   = 2'b01;
  localparam logic [1:0] LN_K   = 2'b10;
endpackage

// File: rtl/usres_det.sv
module usres_det #(
  parameter int DET_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic k_in,
  output logic hit
);
  localparam int CW = $clog2(DET_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DET_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(DET_CYC);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      hit     <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (!enable || !k_in) begin
        run_cnt <= '0;
      end else if (run_cnt != FULL) begin
        run_cnt <= run_cnt + 1'b1;
        if (run_cnt == LAST) hit <= 1'b1;
      end
    end
  end

  assert_hit_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  assert_hit_after_k_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(k_in) && $past(enable));
endmodule

// File: rtl/usres_timer.sv
module usres_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] top_q;

  assign expire = run && tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      top_q <= '0;
    end else if (load) begin
      cnt   <= load_val;
      top_q <= load_val;
    end else if (run && tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_q);
endmodule

// File: rtl/usb_resume_ctrl.sv
module usb_resume_ctrl
  import usres_pkg::*;
#(
  parameter int DEV_US   = 10000,
  parameter int HOST_US  = 21000,
  parameter int QUIET_US = 10000,
  parameter int DET_CYC  = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       us_tick,
  input  logic       host_mode,
  input  logic       resume_req,
  input  logic       bus_suspended,
  input  logic [1:0] line_state,
  output logic       drive_en,
  output logic [1:0] drive_line,
  output logic       resume_irq,
  output logic       susp_exit,
  output logic       sof_en,
  output logic       traffic_ok
);
  localparam int MAXV = (HOST_US > DEV_US) ? ((HOST_US > QUIET_US) ? HOST_US : QUIET_US)
                                           : ((DEV_US > QUIET_US) ? DEV_US : QUIET_US);
  localparam int CW = $clog2(MAXV + 1);

  usres_st_t st, st_nx;
  logic role_q, det_hit, start, expire, load;
  logic [CW-1:0] load_val;

  usres_det #(.DET_CYC(DET_CYC)) u_det (
    .clk(clk), .rst(rst), .enable(st != ST_DRIVE),
    .k_in(line_state == LN_K), .hit(det_hit));

  usres_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .run(st != ST_IDLE), .tick(us_tick), .expire(expire));

  assign start    = (st == ST_IDLE) && (resume_req || (host_mode && det_hit));
  assign load     = start || (st == ST_DRIVE && expire && role_q);
  assign load_val = start ? (host_mode ? CW'(HOST_US) : CW'(DEV_US)) : CW'(QUIET_US);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start) st_nx = ST_DRIVE;
      ST_DRIVE: if (expire) st_nx = role_q ? ST_QUIET : ST_IDLE;
      ST_QUIET: if (expire) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      role_q     <= 1'b0;
      drive_en   <= 1'b0;
      traffic_ok <= 1'b1;
      sof_en     <= 1'b0;
      susp_exit  <= 1'b0;
      resume_irq <= 1'b0;
    end else begin
      st         <= st_nx;
      drive_en   <= (st_nx == ST_DRIVE);
      traffic_ok <= (st_nx == ST_IDLE);
      resume_irq <= det_hit;
      if (start) role_q <= host_mode;
      if (!host_mode) sof_en <= 1'b0;
      else if (st == ST_DRIVE && expire && role_q) sof_en <= 1'b1;
      susp_exit  <= bus_suspended &&
                    (start || (line_state != LN_J && st != ST_DRIVE));
    end
  end

  assign drive_line = drive_en ? LN_K : LN_J;

  assert_no_traffic_in_drive_R4: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> !traffic_ok);
  assert_quiet_not_redrive_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_QUIET) |=> (st != ST_DRIVE));
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    resume_irq |=> !resume_irq);
  assert_no_irq_while_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DRIVE) |=> !det_hit);
endmodule

// File: tb/usb_resume_ctrl_tb.sv
module usb_resume_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEV  = 5;
  localparam int HOST = 9;
  localparam int QT   = 6;
  localparam int DET  = 4;
  localparam int TICK_DIV = 3;

  logic clk = 0, rst = 1, us_tick = 0, host_mode = 0, resume_req = 0, bus_suspended = 0;
  logic [1:0] line_state = 2'b01;
  logic drive_en, resume_irq, susp_exit, sof_en, traffic_ok;
  logic [1:0] drive_line;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_resume_ctrl #(.DEV_US(DEV), .HOST_US(HOST), .QUIET_US(QT), .DET_CYC(DET)) u_dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .host_mode(host_mode),
    .resume_req(resume_req), .bus_suspended(bus_suspended), .line_state(line_state),
    .drive_en(drive_en), .drive_line(drive_line), .resume_irq(resume_irq),
    .susp_exit(susp_exit), .sof_en(sof_en), .traffic_ok(traffic_ok));

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % TICK_DIV;
      us_tick = (ph == 0);
    end
  end

  function automatic int exp_pulses(int len);
    return (len >= DET) ? 1 : 0;
  endfunction

  function automatic int exp_drive(bit host);
    return host ? HOST : DEV;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // measure ticks while drive_en high; optionally poke a request mid-drive
  task automatic measure_drive(output int ticks, input bit poke);
    int guard = 0;
    ticks = 0;
    while (!drive_en && guard < 20) begin @(negedge clk); guard++; end
    while (drive_en && guard < 500) begin
      if (drive_line != 2'b10) check("R2 drive_line", drive_line, 2);
      if (traffic_ok) check("R4 traffic during drive", traffic_ok, 0);
      if (us_tick) ticks++;
      resume_req = poke && (ticks == 2);
      @(negedge clk); guard++;
    end
    resume_req = 0;
  endtask

  task automatic measure_quiet(output int ticks, input bit poke);
    int guard = 0;
    ticks = 0;
    while (!traffic_ok && guard < 500) begin
      if (us_tick) ticks++;
      resume_req = poke && (ticks == 1);
      if (drive_en) check("R8 redrive in quiet", drive_en, 0);
      @(negedge clk); guard++;
    end
    resume_req = 0;
  endtask

  task automatic do_drive(bit host, bit poke_d, bit poke_q, string rq);
    int t, q;
    host_mode = host;
    resume_req = 1;
    @(negedge clk);
    resume_req = 0;
    measure_drive(t, poke_d);
    check(rq, t, exp_drive(host));
    measure_quiet(q, poke_q);
    check("R4 quiet ticks", q, host ? QT : 0);
    if (host) check("R9 sof_en after host drive", sof_en, 1);
    repeat (2) @(negedge clk);
    check("R8 no restart", drive_en, 0);
  endtask

  task automatic k_burst(int len, output int pulses, output int drives);
    pulses = 0; drives = 0;
    for (int i = 0; i < len + 3; i++) begin
      line_state = (i < len) ? 2'b10 : 2'b01;
      @(negedge clk);
      if (resume_irq) pulses++;
      if (drive_en) drives++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int p, d, t;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 drive_en", drive_en, 0);
    check("R1 traffic_ok", traffic_ok, 1);
    check("R1 resume_irq", resume_irq, 0);
    check("R1 sof_en", sof_en, 0);
    check("R1 susp_exit", susp_exit, 0);
    check("R2 idle line J", drive_line, 1);
    // R2, R3, R4, R8, R9
    do_drive(0, 0, 0, "R2 device ticks");
    do_drive(1, 0, 0, "R3 host ticks");
    do_drive(0, 1, 0, "R8 poke device drive");
    do_drive(1, 1, 1, "R8 poke host drive/quiet");
    host_mode = 0;
    @(negedge clk); @(negedge clk);
    check("R9 sof_en cleared", sof_en, 0);
    // R5 directed
    k_burst(DET - 1, p, d);
    check("R5 short run", p, 0);
    k_burst(DET, p, d);
    check("R5 exact run", p, 1);
    k_burst(DET + 5, p, d);
    check("R5 long run single pulse", p, 1);
    check("R5 device no drive", d, 0);
    // R6: K during drive
    resume_req = 1; @(negedge clk); resume_req = 0;
    line_state = 2'b10;
    p = 0;
    while (drive_en) begin if (resume_irq) p++; @(negedge clk); end
    line_state = 2'b01;
    check("R6 no irq while driving", p, 0);
    repeat (DET + 2) @(negedge clk);
    // R7
    host_mode = 1;
    k_burst(DET, p, d);
    check("R7 host irq", p, 1);
    check("R7 host auto drive started", d > 0, 1);
    line_state = 2'b01;
    measure_drive(t, 0);
    check("R7 host auto drive ticks", t + 1 >= HOST && t <= HOST, 1);
    measure_quiet(t, 0);
    host_mode = 0;
    repeat (2) @(negedge clk);
    // R10
    bus_suspended = 1;
    @(negedge clk);
    check("R10 idle J no exit", susp_exit, 0);
    line_state = 2'b00;
    @(negedge clk);
    line_state = 2'b01;
    check("R10 activity exit", susp_exit, 1);
    @(negedge clk);
    resume_req = 1;
    @(negedge clk);
    resume_req = 0;
    check("R10 drive start exit", susp_exit, 1);
    bus_suspended = 0;
    measure_drive(t, 0);
    repeat (2) @(negedge clk);
    // random R5 bursts
    for (int i = 0; i < 24; i++) begin
      int len = 1 + int'($urandom_range(2 * DET));
      k_burst(len, p, d);
      check("R5 random burst", p, exp_pulses(len));
    end
    // random drives R2/R3
    for (int i = 0; i < 6; i++) begin
      bit h = 1'($urandom_range(1));
      do_drive(h, 1'($urandom_range(1)), 0, h ? "R3 random host" : "R2 random device");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule